// File: doc/BRIEF.md
# Bit-Serial Adder with Selectable Output Timing

This block adds two unsigned binary numbers that arrive one bit pair per clock, least significant bit first. Each clock it takes one bit of each operand and produces one bit of the sum. The only thing it remembers between bits is the carry, which sits in one flip-flop. A synchronous active-low clear empties the carry so that a new addition can begin. Word length is not fixed: whoever drives the operands sets it. After the last bit pair of a word, the carry state holds the carry out of that word.

A parameter picks one of two output timings.

- **Combinational form.** The sum bit is formed from the current operand bits and the stored carry, so it is valid in the same cycle as the bits it belongs to.
- **Registered form.** The block is a four-state machine whose state is the pair (carry, sum). The sum output is read from the state alone, so each sum bit appears one clock after its operand bits were sampled. In this form the clear also empties the stored sum bit.

Top module: `serial_adder`

## Requirements
- R1: When the bit pairs of two operands are fed LSB first after a clear, the collected sum bits equal (A+B) modulo 2^n for an n-bit word. After the last pair, carry_q equals bit n of A+B. This holds in both output forms; in the registered form every sum bit is taken one cycle later.
- R2: With OUT_MODE=0, sum_bit equals a_bit xor b_bit xor carry_q in the same cycle.
- R3: When a_bit and b_bit are both 1 at a clock edge (clr_n high), carry_q is 1 after that edge. When both are 0, carry_q is 0 after that edge.
- R4: When clr_n is 0 at a clock edge, carry_q is 0 after that edge, whatever the values of a_bit and b_bit.
- R5: With OUT_MODE=1, sum_bit after an edge with clr_n high equals a_bit xor b_bit xor carry_q as sampled at that edge.
- R6: With OUT_MODE=1, when clr_n is 0 at a clock edge, sum_bit is 0 after that edge.
- R7: With OUT_MODE=1, sum_bit does not change when a_bit or b_bit change between clock edges.
- R8: When a_bit and b_bit differ at an edge (clr_n high), carry_q keeps its value across that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous active-low clear; starts a new addition |
| a_bit | input | 1 | Current bit of operand A, LSB first |
| b_bit | input | 1 | Current bit of operand B, LSB first |
| sum_bit | output | 1 | Sum bit (same cycle when OUT_MODE=0, next cycle when OUT_MODE=1) |
| carry_q | output | 1 | Stored carry state |

## Verification
The clocked properties assume three things about the inputs: a_bit and b_bit are clean 0/1 values at every rising edge, clr_n is low at the first edge so that the state is known, and they hold no meaning while clr_n is low. The bench keeps to these rules. It holds the clear through the first edge and changes every input only on the falling edge. Its mid-cycle operand toggles end before the next rising edge. It sweeps every pair of 4-bit operands through both forms at once, each word preceded by a clear cycle, and checks a clear issued while the carry is set and both operand bits are 1.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

  // Output timing selection
  localparam int OUT_COMB = 0;
  localparam int OUT_REG  = 1;

  // Four-state encoding of the registered form: bit 1 = carry, bit 0 = sum
  typedef enum logic [1:0] {
    ST_C0_S0 = 2'b00,
    ST_C0_S1 = 2'b01,
    ST_C1_S0 = 2'b10,
    ST_C1_S1 = 2'b11
  } add_state_t;

  function automatic add_state_t pack_state(input logic carry, input logic sum);
    add_state_t st;
    case ({carry, sum})
      2'b00:   st = ST_C0_S0;
      2'b01:   st = ST_C0_S1;
      2'b10:   st = ST_C1_S0;
      default: st = ST_C1_S1;
    endcase
    return st;
  endfunction

endpackage

// File: rtl/sadd_bit_cell.sv
// Per-bit combinational slice: sum bit plus carry generate/kill terms.
module sadd_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic gen_o,
  output logic kill_o
);
  always_comb begin
    sum_o  = a_i ^ b_i ^ c_i;
    gen_o  = a_i & b_i;
    kill_o = ~a_i & ~b_i;
  end
endmodule

// File: rtl/sadd_jk_carry.sv
// Carry flip-flop in JK form: J = generate, K = kill.
module sadd_jk_carry (
  input  logic clk,
  input  logic clr_n,
  input  logic j_i,
  input  logic k_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!clr_n) q_o <= 1'b0;
    else        q_o <= (j_i & ~q_o) | (~k_i & q_o);
  end
endmodule

// File: rtl/sadd_moore_fsm.sv
// Registered form: four-state machine holding (carry, sum).
module sadd_moore_fsm
  import serial_add_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic a_i,
  input  logic b_i,
  input  logic sum_i,
  input  logic gen_i,
  input  logic kill_i,
  output logic carry_o,
  output logic sum_o
);
  add_state_t state_q, state_d;
  logic       carry_nxt;

  always_comb begin
    carry_nxt = gen_i | (~kill_i & state_q[1]);
    state_d   = pack_state(carry_nxt, sum_i);
  end

  always_ff @(posedge clk) begin
    if (!clr_n) state_q <= ST_C0_S0;
    else        state_q <= state_d;
  end

  assign carry_o = state_q[1];
  assign sum_o   = state_q[0];

  // R5
  moore_delay_chk: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (sum_o == $past(a_i ^ b_i ^ carry_o)));

  // R6
  moore_clr_chk: assert property (@(posedge clk)
    !clr_n |=> (sum_o == 1'b0));
endmodule

// File: rtl/serial_adder.sv
module serial_adder
  import serial_add_pkg::*;
#(
  parameter int OUT_MODE = OUT_COMB
) (
  input  logic clk,
  input  logic clr_n,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic carry_q
);
  logic cell_sum, cell_gen, cell_kill;

  sadd_bit_cell u_cell (
    .a_i   (a_bit),
    .b_i   (b_bit),
    .c_i   (carry_q),
    .sum_o (cell_sum),
    .gen_o (cell_gen),
    .kill_o(cell_kill)
  );

  generate
    if (OUT_MODE == OUT_REG) begin : g_reg
      sadd_moore_fsm u_fsm (
        .clk    (clk),
        .clr_n  (clr_n),
        .a_i    (a_bit),
        .b_i    (b_bit),
        .sum_i  (cell_sum),
        .gen_i  (cell_gen),
        .kill_i (cell_kill),
        .carry_o(carry_q),
        .sum_o  (sum_bit)
      );
    end else begin : g_comb
      sadd_jk_carry u_carry (
        .clk  (clk),
        .clr_n(clr_n),
        .j_i  (cell_gen),
        .k_i  (cell_kill),
        .q_o  (carry_q)
      );
      assign sum_bit = cell_sum;
    end
  endgenerate

  // R3
  carry_set_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (a_bit && b_bit) |=> carry_q);

  // R3
  carry_kill_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!a_bit && !b_bit) |=> !carry_q);

  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (a_bit != b_bit) |=> $stable(carry_q));

  // R4
  clear_carry_chk: assert property (@(posedge clk)
    !clr_n |=> !carry_q);
endmodule

// File: tb/serial_adder_test.sv
module serial_adder_test;
  localparam int W = 4;

  logic clk = 1'b0;
  logic clr_n, a, b;
  logic sum_c, car_c, sum_r, car_r;
  int   n_chk = 0;
  int   n_bad = 0;

  always #4 clk = ~clk;

  serial_adder #(.OUT_MODE(0)) uut (
    .clk(clk), .clr_n(clr_n), .a_bit(a), .b_bit(b),
    .sum_bit(sum_c), .carry_q(car_c));

  serial_adder #(.OUT_MODE(1)) uut_moore (
    .clk(clk), .clr_n(clr_n), .a_bit(a), .b_bit(b),
    .sum_bit(sum_r), .carry_q(car_r));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_word(input int av, input int bv);
    int ec, ew, es;
    logic [W-1:0] cw, rw;
    logic s0;
    ec = 0; cw = '0; rw = '0;
    ew = (av + bv) & ((1 << W) - 1);
    es = 0;
    @(negedge clk);
    clr_n = 1'b0; a = 1'b0; b = 1'b0;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk("R4 comb carry after clear", car_c, 0);
        chk("R4 reg carry after clear", car_r, 0);
        chk("R6 reg sum after clear", sum_r, 0);
      end else begin
        rw[i-1] = sum_r;
        chk("R5 reg sum one cycle late", sum_r, es);
      end
      chk("R3/R8 comb carry", car_c, ec);
      chk("R3/R8 reg carry", car_r, ec);
      clr_n = 1'b1; a = av[i]; b = bv[i];
      #1 s0 = sum_r;
      a = ~a; b = ~b;
      #1 chk("R7 reg sum ignores input change", sum_r, s0);
      a = av[i]; b = bv[i];
      #1 chk("R2 comb sum same cycle", sum_c, int'(a ^ b ^ ec[0]));
      cw[i] = sum_c;
      es = int'(a ^ b ^ ec[0]);
      ec = (int'(a) + int'(b) + ec) >> 1;
    end
    @(negedge clk);
    rw[W-1] = sum_r;
    chk("R5 reg sum last bit", sum_r, es);
    chk("R1 comb sum word", int'(cw), ew);
    chk("R1 reg sum word", int'(rw), ew);
    chk("R1 comb carry out", car_c, (av + bv) >> W);
    chk("R1 reg carry out", car_r, (av + bv) >> W);
  endtask

  initial begin
    clr_n = 1'b0; a = 1'b0; b = 1'b0;
    @(negedge clk);
    chk("R4 reset comb carry", car_c, 0);
    chk("R4 reset reg carry", car_r, 0);
    chk("R6 reset reg sum", sum_r, 0);
    for (int x = 0; x < (1 << W); x++)
      for (int y = 0; y < (1 << W); y++)
        run_word(x, y);
    // Clear while carry is set and both operand bits are 1
    chk("R1 carry set before clear", car_c, 1);
    @(negedge clk);
    clr_n = 1'b0; a = 1'b1; b = 1'b1;
    @(negedge clk);
    chk("R4 clear beats generate comb", car_c, 0);
    chk("R4 clear beats generate reg", car_r, 0);
    chk("R6 clear zeroes reg sum", sum_r, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule